// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast source clock by an integer C and delivers an output clock whose high time is set in half-source-period steps. One output period spans C source cycles. A high-time setting H, counted in half periods, fixes how long the output stays high. The output then stays low for the rest of the period, which is 2C−H half periods. The resolution is therefore 50%/C. For C = 10, the selectable duty cycles run from 5% to 90% in 5% steps. The top step, just below 100%, is refused.

A small legality checker examines the live settings and reports on `cfg_ok` whether they can be run. When `fb_mode` is asserted the output is meant to drive a feedback path, and only the exact 50% setting (H = C) is accepted. When C = 1 the divider steps aside and gates the source clock through at 50%; only H = 1 is legal in that case.

The divider is built as a three-state machine clocked on the rising source edge:
- IDLE holds the output low.
- HIGH lasts ⌈H/2⌉ source cycles.
- LOW fills the rest of the period.

The transitions are:
- start (IDLE→HIGH): taken when enabled with legal settings.
- hi_done (HIGH→LOW): taken when the high count is reached.
- restart (LOW→HIGH): taken at the period end while still enabled and legal. C and H are latched at that point, so new settings take effect only at an output rising edge.
- stop (LOW→IDLE): taken at the period end otherwise.

For odd H, a falling-edge copy of the HIGH flag is ANDed with the flag itself, which trims the pulse by half a period.

Top module: `pdiv_top`

## Requirements
- R1: While `rst` is high (synchronous, rising source edge), `clk_out` is low. After release with `en` high, the first output activity is a high phase.
- R2: For C ≥ 2 and even legal H, `clk_out` stays high for exactly H half-periods of `clk_src`.
- R3: For C ≥ 2 and any legal H, each low phase lasts 2C−H half-periods, so the output period is C source cycles.
- R4: For odd legal H, `clk_out` stays high for exactly H half-periods. Its rising edge follows a falling source edge.
- R5: `cfg_ok` is 1 exactly when the settings are legal. For C ≥ 2, legal means 1 ≤ H ≤ 2C−2 (H = 0 and H ≥ 2C−1 are illegal). For C = 1, only H = 1 is legal. C = 0 is always illegal.
- R6: With `en` high and illegal settings, no period starts and `clk_out` stays low.
- R7: With `fb_mode` = 1, a setting for C ≥ 2 is legal only if H = C (50% duty).
- R8: A change of H made during a high phase does not alter that phase. The new H applies from the next output rising edge.
- R9: With C = 1, H = 1 and `en` high, `clk_out` follows `clk_src`: high for one half-period, then low for one.
- R10: When `en` falls, the period in progress completes. `clk_out` then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; C must not change while high |
| div_c | input | CW | Divide value C |
| high_h | input | CW+1 | High time H in half source periods |
| fb_mode | input | 1 | Output drives a feedback path; forces 50% |
| clk_out | output | 1 | Divided clock |
| cfg_ok | output | 1 | Current settings are legal |

## Verification
A wrong count or a wrong state in the machine shows up at `clk_out` within one output period of C source cycles. Depending on the fault, the pulse comes out too long or too short, the low phase stretches, or the clock stops or never starts. A wrong falling-edge stage shows up as every odd-H pulse being off by one half-period. A fault in the legality logic shows up at once on `cfg_ok`. It also shows up within a few periods as a clock running under an illegal setting, or a clock missing under a legal one. Late or early latching of settings shows up as a wrong length on the high phase during which H changed.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;
endpackage

// File: rtl/pdiv_cfg_check.sv
module pdiv_cfg_check #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] c,
    input  logic [CW:0]   h,
    input  logic          fb,
    output logic          ok
);
    localparam int HW = CW + 1;

    logic [HW-1:0] c_ext;
    logic [HW-1:0] h_max;

    always_comb begin
        c_ext = {1'b0, c};
        h_max = {c, 1'b0} - HW'(2);
        if (c == CW'(1)) begin
            ok = (h == HW'(1));
        end else if (c >= CW'(2)) begin
            ok = (h != '0) && (h <= h_max) && (!fb || (h == c_ext));
        end else begin
            ok = 1'b0;
        end
    end
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core
    import pdiv_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          cfg_ok,
    input  logic [CW-1:0] c,
    input  logic [CW:0]   h,
    output logic          p,
    output logic          odd
);
    div_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] c_q, k_q;
    logic          odd_q;
    logic          load;
    logic          go;
    logic [CW-1:0] k_in;

    always_comb begin
        go   = en && cfg_ok && (c != CW'(1));
        k_in = h[CW:1] + {{(CW-1){1'b0}}, h[0]};
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_n = ST_HIGH;
                    cnt_n   = CW'(1);
                    load    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (cnt_q == k_q) begin
                    state_n = ST_LOW;
                    cnt_n   = CW'(1);
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_LOW: begin
                if (cnt_q == (c_q - k_q)) begin
                    if (go) begin
                        state_n = ST_HIGH;
                        cnt_n   = CW'(1);
                        load    = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            c_q     <= '0;
            k_q     <= '0;
            odd_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (load) begin
                c_q   <= c;
                k_q   <= k_in;
                odd_q <= h[0];
            end
        end
    end

    always_comb begin
        p   = (state_q == ST_HIGH);
        odd = odd_q;
    end

    // R2 R4: the high phase never outruns its latched count
    p_high_len_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH) |-> (cnt_q <= k_q));

    // R3: the low phase never outruns the rest of the period
    p_low_len_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW) |-> (cnt_q <= (c_q - k_q)));

    // R6: a running period always carries a legal high count
    p_start_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIGH) |-> ((k_q >= CW'(1)) && (k_q < c_q)));

    // R10: leaving LOW for IDLE happens only at the period end without run permission
    p_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW && state_n == ST_IDLE) |-> !go);
endmodule

// File: rtl/pdiv_edge_join.sv
module pdiv_edge_join (
    input  logic clk,
    input  logic rst,
    input  logic p,
    input  logic odd,
    input  logic byp_req,
    output logic clk_out
);
    logic n_q;
    logic byp_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            n_q   <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            n_q   <= p;
            byp_q <= byp_req;
        end
    end

    always_comb begin
        clk_out = (byp_q & clk) | (odd ? (p & n_q) : p);
    end

    // R9: pass-through and divided paths are never active together
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        !(byp_q && p));
endmodule

// File: rtl/pdiv_top.sv
module pdiv_top #(
    parameter int CW = 8
) (
    input  logic          clk_src,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] div_c,
    input  logic [CW:0]   high_h,
    input  logic          fb_mode,
    output logic          clk_out,
    output logic          cfg_ok
);
    logic ok;
    logic p;
    logic odd;
    logic byp_req;

    pdiv_cfg_check #(.CW(CW)) i_check (
        .c  (div_c),
        .h  (high_h),
        .fb (fb_mode),
        .ok (ok)
    );

    pdiv_core #(.CW(CW)) i_core (
        .clk    (clk_src),
        .rst    (rst),
        .en     (en),
        .cfg_ok (ok),
        .c      (div_c),
        .h      (high_h),
        .p      (p),
        .odd    (odd)
    );

    always_comb begin
        byp_req = en && ok && (div_c == CW'(1));
        cfg_ok  = ok;
    end

    pdiv_edge_join i_join (
        .clk     (clk_src),
        .rst     (rst),
        .p       (p),
        .odd     (odd),
        .byp_req (byp_req),
        .clk_out (clk_out)
    );
endmodule

// File: tb/test_pdiv_top.sv
`timescale 1ns/1ps
module test_pdiv_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;
    localparam int CW = 8;

    logic          clk_src = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [CW-1:0] div_c = 8'd4;
    logic [CW:0]   high_h = 9'd4;
    logic          fb_mode = 1'b0;
    logic          clk_out;
    logic          cfg_ok;

    int checks = 0;
    int errors = 0;
    int cur_c = 4;
    bit done = 0;

    pdiv_top #(.CW(CW)) i_pdiv_top (
        .clk_src (clk_src),
        .rst     (rst),
        .en      (en),
        .div_c   (div_c),
        .high_h  (high_h),
        .fb_mode (fb_mode),
        .clk_out (clk_out),
        .cfg_ok  (cfg_ok)
    );

    always #(HALF) clk_src = ~clk_src;

    function automatic bit exp_ok(int c, int h, bit fb);
        if (c == 1) return (h == 1);
        if (c < 2) return 0;
        if (h < 1 || h > 2 * c - 2) return 0;
        if (fb && h != c) return 0;
        return 1;
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic halves(int n);
        for (int i = 0; i < n; i++) #(HALF);
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        bit pv;
        hi = 0;
        lo = 0;
        guard = 0;
        forever begin
            pv = clk_out;
            #(HALF);
            guard++;
            if ((!pv && clk_out) || guard > 2000) break;
        end
        while (clk_out && guard < 4000) begin hi++; #(HALF); guard++; end
        while (!clk_out && guard < 4000) begin lo++; #(HALF); guard++; end
    endtask

    task automatic all_low(int n, output bit low);
        low = 1;
        for (int i = 0; i < n; i++) begin
            #(HALF);
            if (clk_out) low = 0;
        end
    endtask

    task automatic run_cfg(int c, int h, bit fb, string tag);
        int hi, lo;
        bit ok, low;
        en = 1'b0;
        halves(2 * cur_c + 6);
        div_c = CW'(c);
        high_h = (CW + 1)'(h);
        fb_mode = fb;
        cur_c = (c < 1) ? 1 : c;
        #(HALF);
        ok = exp_ok(c, h, fb);
        check(cfg_ok == ok, fb ? "R7 cfg_ok" : "R5 cfg_ok", cfg_ok, ok);
        en = 1'b1;
        if (!ok) begin
            all_low(4 * cur_c + 8, low);
            check(low, "R6 output held low", low, 1);
        end else if (c == 1) begin
            measure(hi, lo);
            check(hi == 1, "R9 bypass high", hi, 1);
            check(lo == 1, "R9 bypass low", lo, 1);
        end else begin
            measure(hi, lo);
            check(hi == h, (h % 2) ? "R4 odd high time" : "R2 high time", hi, h);
            check(lo == 2 * c - h, "R3 low time", lo, 2 * c - h);
        end
        if (tag.len() > 0) $display("directed %s done", tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, lo, h, c;
        bit fb, low;
        void'($urandom(32'd4711));
        #2;
        en = 1'b1;
        halves(10);
        check(clk_out == 1'b0, "R1 low in reset", clk_out, 0);
        check(cfg_ok == 1'b1, "R5 cfg_ok c4 h4", cfg_ok, 1);
        rst = 1'b0;
        measure(hi, lo);
        check(hi == 4, "R1 first phase high", hi, 4);
        check(lo == 4, "R3 low after reset", lo, 4);

        run_cfg(10, 1, 0, "c10 5pct");
        run_cfg(10, 18, 0, "c10 90pct");
        run_cfg(10, 19, 0, "c10 top step");
        run_cfg(10, 0, 0, "h zero");
        run_cfg(2, 1, 0, "c2 25pct");
        run_cfg(2, 2, 0, "c2 50pct");
        run_cfg(2, 3, 0, "c2 top step");
        run_cfg(1, 1, 0, "bypass");
        run_cfg(1, 2, 0, "bypass half step");
        run_cfg(0, 1, 0, "c zero");
        run_cfg(6, 6, 1, "feedback 50pct");
        run_cfg(6, 5, 1, "feedback off 50");

        // R8: change H during a high phase
        run_cfg(8, 4, 0, "");
        measure(hi, lo);
        high_h = 9'd10;
        hi = 0;
        while (clk_out && hi < 100) begin hi++; #(HALF); end
        check(hi == 4, "R8 current phase unchanged", hi, 4);
        measure(hi, lo);
        check(hi == 10, "R8 new high time", hi, 10);
        check(lo == 6, "R8 new low time", lo, 6);

        // R10: drop enable during a high phase
        run_cfg(5, 3, 0, "");
        measure(hi, lo);
        en = 1'b0;
        hi = 0;
        while (clk_out && hi < 100) begin hi++; #(HALF); end
        check(hi == 3, "R10 period completes", hi, 3);
        all_low(30, low);
        check(low, "R10 stays low", low, 1);

        for (int i = 0; i < 40; i++) begin
            c = 2 + int'($urandom % 12);
            h = int'($urandom % (2 * c + 1));
            fb = (($urandom % 4) == 0);
            run_cfg(c, h, fb, "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule